// File: doc/BRIEF.md
# Residue-Checked Pipelined Execution Unit

A 16-bit execution unit that performs pass-through, constants, add and subtract, shifts and rotates, and multiply or multiply-accumulate, and checks every result with a modulo-3 residue code. In the issue cycle, side logic predicts the result's residue from the residues of the operands and from a few datapath by-products: the adder carry, the bits lost by a shift, the dropped upper half of a product, and the accumulate carry. That prediction travels down the pipe beside the result. One stage after the result is registered, the residue of the registered result is generated. One stage after that, an XOR equality check between the two 2-bit residues raises the error flag.

A fault-injection mask is XORed into the result register. This lets an upstream harness or a bench corrupt chosen result bits without touching the prediction path.

Top module: `rc_exu`

## Requirements
- R1: The class code `cls_i` selects the operation: 000 copies A, 001 copies B, 010 gives 1, 011 gives 0, 100 is the adder, 101 is the shifter, 110 is the multiplier and 111 gives 0. `result_o` is valid on the cycle after issue.
- R2: The adder sub-codes on `sub_i` are: 00 is A+B, 01 is A+B+cin, 10 is A−B, and 11 is A+~B+cin (that is, A−B−1+cin). All four wrap modulo 2^16.
- R3: The shift amount is `b_i[3:0]`. The shifter sub-codes are: 00 is a logical left shift, 01 a logical right shift, 10 a left rotate and 11 a right rotate. An amount of 0 returns A unchanged.
- R4: The multiplier sub-codes are: 00 is the unsigned product, 01 the signed product, 10 the unsigned product plus `acc_i`, and 11 the signed product plus `acc_i`. The result is always the low 16 bits, so the signed and unsigned forms give identical results.
- R5: `err_o` rises exactly two cycles after the `result_o` it judges whenever that result's residue modulo 3 differs from the predicted residue. The result is the true value XOR `flip_i`.
- R6: With `flip_i` zero, `err_o` stays low for every operation, including carries, borrows, shift spill, rotate wrap and product overflow.
- R7: `valid_o` is `valid_i` delayed by one cycle. `err_o` is high only two cycles after a valid result.
- R8: While `rst_ni` is low, `valid_o`, `result_o` and `err_o` are all 0.
- R9: Any single flipped result bit is flagged. A two-bit flip that turns adjacent bits 00 into 11 changes the value by 3·2^i and is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Issue strobe |
| cls_i | input | 3 | Operation class |
| sub_i | input | 2 | Sub-operation within the class |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B; bits [3:0] give the shift amount |
| cin_i | input | 1 | Carry-in for the carry forms of the adder |
| acc_i | input | 16 | Accumulator addend |
| flip_i | input | 16 | Fault mask XORed into the result |
| valid_o | output | 1 | Result valid |
| result_o | output | 16 | Result |
| err_o | output | 1 | Residue mismatch flag |

## Verification
A result issued at clock edge n is on `result_o` after edge n+1. Its error verdict is on `err_o` after edge n+3, which is two cycles after the result. The scoreboard pops one expected item on each cycle where `valid_o` is high, so results are compared in the cycle they are due. The expected error bit is then held in a two-entry history, so `err_o` is judged exactly two cycles later. Cycles that carry no valid result are checked for a low `err_o`. Expected results come from plain arithmetic on the operands, and expected flags come from comparing `%3` of the flipped and unflipped values.

// File: rtl/rc_exu_pkg.sv
package rc_exu_pkg;

  typedef enum logic [2:0] {
    CLS_PASS_A = 3'b000,
    CLS_PASS_B = 3'b001,
    CLS_ONE    = 3'b010,
    CLS_ZERO   = 3'b011,
    CLS_ADD    = 3'b100,
    CLS_SHIFT  = 3'b101,
    CLS_MAC    = 3'b110,
    CLS_RSVD   = 3'b111
  } cls_e;

  // residues are canonical 0..2
  function automatic logic [1:0] r3_norm(input logic [1:0] d);
    return (d == 2'd3) ? 2'd0 : d;
  endfunction

  function automatic logic [1:0] r3_add(input logic [1:0] x, input logic [1:0] y);
    logic [2:0] s;
    logic [1:0] f;
    s = {1'b0, x} + {1'b0, y};
    f = s[1:0] + {1'b0, s[2]};  // end-around carry
    return r3_norm(f);
  endfunction

  function automatic logic [1:0] r3_neg(input logic [1:0] x);
    return (x == 2'd0) ? 2'd0 : 2'd3 - x;
  endfunction

  function automatic logic [1:0] r3_sub(input logic [1:0] x, input logic [1:0] y);
    return r3_add(x, r3_neg(y));
  endfunction

  function automatic logic [1:0] r3_mul(input logic [1:0] x, input logic [1:0] y);
    if (x == 2'd0 || y == 2'd0) return 2'd0;
    return (x == y) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/rc_exu_res3.sv
module rc_exu_res3
  import rc_exu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] v_i,
  output logic [1:0]   r_o
);
  localparam int unsigned ND = (W + 1) / 2;

  logic [2*ND-1:0] vx;
  assign vx = (2*ND)'(v_i);

  // 4 == 1 mod 3: fold base-4 digits
  always_comb begin
    logic [1:0] r;
    r = 2'd0;
    for (int i = 0; i < ND; i++) r = r3_add(r, r3_norm(vx[2*i +: 2]));
    r_o = r;
  end
endmodule

// File: rtl/rc_exu_dp.sv
module rc_exu_dp
  import rc_exu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  cls_e         cls_i,
  input  logic [1:0]   sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic [W-1:0] spill_o,
  output logic [W-1:0] hi_o
);
  localparam int unsigned SW = $clog2(W);

  logic [SW-1:0]  k;
  logic [W-1:0]   bx, add_s, shl, shr, rol, ror, spl_l, spl_r, lo, mac_s;
  logic           ci, add_c, mac_c;
  logic [2*W-1:0] prod;

  assign k = b_i[SW-1:0];

  always_comb begin
    bx = sub_i[1] ? ~b_i : b_i;
    ci = sub_i[0] ? cin_i : sub_i[1];
    {add_c, add_s} = {1'b0, a_i} + {1'b0, bx} + (W+1)'(ci);

    shl   = a_i << k;
    shr   = a_i >> k;
    rol   = (a_i << k) | (a_i >> (W - k));
    ror   = (a_i >> k) | (a_i << (W - k));
    spl_l = a_i >> (W - k);
    spl_r = a_i & ~({W{1'b1}} << k);

    // low half identical for signed/unsigned
    prod  = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
    lo    = prod[W-1:0];
    {mac_c, mac_s} = {1'b0, lo} + {1'b0, acc_i};
  end

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    unique case (cls_i)
      CLS_PASS_A: res_o = a_i;
      CLS_PASS_B: res_o = b_i;
      CLS_ONE:    res_o = W'(1);
      CLS_ADD: begin
        res_o   = add_s;
        carry_o = add_c;
      end
      CLS_SHIFT: begin
        unique case (sub_i)
          2'b00:   res_o = shl;
          2'b01:   res_o = shr;
          2'b10:   res_o = rol;
          default: res_o = ror;
        endcase
      end
      CLS_MAC: begin
        res_o   = sub_i[1] ? mac_s : lo;
        carry_o = sub_i[1] & mac_c;
      end
      default: res_o = '0;
    endcase
  end

  assign spill_o = sub_i[0] ? spl_r : spl_l;
  assign hi_o    = prod[2*W-1:W];
endmodule

// File: rtl/rc_exu_pred.sv
module rc_exu_pred
  import rc_exu_pkg::*;
(
  input  cls_e       cls_i,
  input  logic [1:0] sub_i,
  input  logic       k_odd_i,
  input  logic       cin_i,
  input  logic       carry_i,
  input  logic [1:0] ra_i,
  input  logic [1:0] rb_i,
  input  logic [1:0] racc_i,
  input  logic [1:0] rspill_i,
  input  logic [1:0] rhi_i,
  output logic [1:0] pred_o
);
  logic [1:0] p2, rbx, rci, rco, rprod;

  always_comb begin
    p2    = k_odd_i ? 2'd2 : 2'd1;              // 2^k mod 3
    rbx   = sub_i[1] ? r3_neg(rb_i) : rb_i;     // ~b == -b (2^W-1 == 0 mod 3)
    rci   = {1'b0, sub_i[0] ? cin_i : sub_i[1]};
    rco   = {1'b0, carry_i};                    // dropped 2^W weighs 1
    rprod = r3_sub(r3_mul(ra_i, rb_i), rhi_i);
    pred_o = 2'd0;
    unique case (cls_i)
      CLS_PASS_A: pred_o = ra_i;
      CLS_PASS_B: pred_o = rb_i;
      CLS_ONE:    pred_o = 2'd1;
      CLS_ADD:    pred_o = r3_sub(r3_add(r3_add(ra_i, rbx), rci), rco);
      CLS_SHIFT: begin
        unique case (sub_i)
          2'b00:   pred_o = r3_sub(r3_mul(ra_i, p2), rspill_i);
          2'b01:   pred_o = r3_mul(r3_sub(ra_i, rspill_i), p2);
          default: pred_o = r3_mul(ra_i, p2);
        endcase
      end
      CLS_MAC:    pred_o = sub_i[1] ? r3_sub(r3_add(rprod, racc_i), rco) : rprod;
      default:    pred_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/rc_exu.sv
module rc_exu
  import rc_exu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [2:0]   cls_i,
  input  logic [1:0]   sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] flip_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         err_o
);
  localparam int unsigned NR = 5;

  cls_e         cls;
  logic [W-1:0] dp_res, dp_spill, dp_hi;
  logic         dp_carry;
  logic [W-1:0] rg_in  [NR];
  logic [1:0]   rg_out [NR];
  logic [1:0]   pred, rres;

  logic         v1, v2, err_q;
  logic [W-1:0] res_q;
  logic [1:0]   pred_q, pred2_q, rres_q;

  assign cls = cls_e'(cls_i);

  rc_exu_dp #(.W(W)) u_dp (
    .cls_i(cls), .sub_i(sub_i), .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .acc_i(acc_i),
    .res_o(dp_res), .carry_o(dp_carry), .spill_o(dp_spill), .hi_o(dp_hi)
  );

  assign rg_in[0] = a_i;
  assign rg_in[1] = b_i;
  assign rg_in[2] = acc_i;
  assign rg_in[3] = dp_spill;
  assign rg_in[4] = dp_hi;

  for (genvar g = 0; g < NR; g++) begin : g_opres
    rc_exu_res3 #(.W(W)) u_res (.v_i(rg_in[g]), .r_o(rg_out[g]));
  end

  rc_exu_pred u_pred (
    .cls_i(cls), .sub_i(sub_i), .k_odd_i(b_i[0]), .cin_i(cin_i), .carry_i(dp_carry),
    .ra_i(rg_out[0]), .rb_i(rg_out[1]), .racc_i(rg_out[2]),
    .rspill_i(rg_out[3]), .rhi_i(rg_out[4]), .pred_o(pred)
  );

  // residue of the registered (possibly corrupted) result
  rc_exu_res3 #(.W(W)) u_res_out (.v_i(res_q), .r_o(rres));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      res_q   <= '0;
      pred_q  <= '0;
      pred2_q <= '0;
      rres_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      v1 <= valid_i;
      if (valid_i) begin
        res_q  <= dp_res ^ flip_i;
        pred_q <= pred;
      end
      v2      <= v1;
      pred2_q <= pred_q;
      rres_q  <= rres;
      err_q   <= v2 & (|(rres_q ^ pred2_q));
    end
  end

  assign valid_o  = v1;
  assign result_o = res_q;
  assign err_o    = err_q;

  initial begin
    if (W % 2 != 0) $error("rc_exu: W must be even for mod-3 wrap identities");
  end
endmodule

// File: rtl/rc_exu_chk.sv
module rc_exu_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [2:0]   cls_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] flip_i,
  input logic         valid_o,
  input logic [W-1:0] result_o,
  input logic         err_o
);
  logic [1:0] seen;  // edges since reset, saturating

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  p_reset_r8: assert property (@(posedge clk_i) !rst_ni |-> (!valid_o && !err_o && result_o == '0));

  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0) |-> (valid_o == $past(valid_i)));

  p_err_after_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen >= 2'd2 && err_o) |-> $past(valid_o, 2));

  p_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd3 && $past(valid_i && flip_i == '0, 3)) |-> !err_o);

  p_single_flip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd3 && $past(valid_i && $countones(flip_i) == 1, 3)) |-> err_o);

  p_pass_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && $past(valid_i && cls_i == 3'b000)) |-> (result_o == $past(a_i ^ flip_i)));

  p_const0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && $past(valid_i && cls_i == 3'b011)) |-> (result_o == $past(flip_i)));
endmodule

bind rc_exu rc_exu_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cls_i(cls_i), .a_i(a_i),
  .flip_i(flip_i), .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
);

// File: tb/tb_rc_exu.sv
module tb_rc_exu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  cls_i = '0;
  logic [1:0]  sub_i = '0;
  logic [15:0] a_i = '0, b_i = '0, acc_i = '0, flip_i = '0;
  logic        cin_i = 1'b0;
  logic        valid_o, err_o;
  logic [15:0] result_o;

  int n_chk = 0, n_fail = 0;
  bit timeout = 0;

  always #2.5 clk = ~clk;

  rc_exu #(.W(16)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .cls_i(cls_i), .sub_i(sub_i),
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .acc_i(acc_i), .flip_i(flip_i),
    .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
  );

  typedef struct {logic [15:0] res; logic err; string tag;} item_t;
  item_t q[$];

  function automatic int m3(input logic [15:0] x);
    return int'(x) % 3;
  endfunction

  function automatic logic [15:0] model(input logic [2:0] c, input logic [1:0] s,
      input logic [15:0] a, input logic [15:0] b, input logic ci, input logic [15:0] acc);
    int k;
    logic [31:0] p, w;
    k = int'(b[3:0]);
    case (c)
      3'd0: return a;
      3'd1: return b;
      3'd2: return 16'd1;
      3'd4: case (s)
        2'd0: return a + b;
        2'd1: return a + b + 16'(ci);
        2'd2: return a - b;
        default: return a - b - 16'd1 + 16'(ci);
      endcase
      3'd5: begin
        w = {a, a};
        case (s)
          2'd0: return a << k;
          2'd1: return a >> k;
          2'd2: begin w = w << k; return w[31:16]; end
          default: begin w = w >> k; return w[15:0]; end
        endcase
      end
      3'd6: begin
        if (s[0]) p = $signed(a) * $signed(b);
        else      p = a * b;
        return s[1] ? p[15:0] + acc : p[15:0];
      end
      default: return 16'd0;
    endcase
  endfunction

  task automatic issue(input logic [2:0] c, input logic [1:0] s, input logic [15:0] a,
      input logic [15:0] b, input logic ci, input logic [15:0] acc, input logic [15:0] fl,
      input string tag);
    item_t it;
    logic [15:0] t;
    @(negedge clk);
    valid_i = 1'b1; cls_i = c; sub_i = s; a_i = a; b_i = b; cin_i = ci; acc_i = acc; flip_i = fl;
    t = model(c, s, a, b, ci, acc);
    it.res = t ^ fl;
    it.err = (m3(t ^ fl) != m3(t));
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; flip_i = '0;
    end
  endtask

  // monitor: result due 1 cycle after issue, flag 2 cycles after result
  logic  d1v = 0, d2v = 0, d1e = 0, d2e = 0;
  string d1t = "", d2t = "";
  always @(negedge clk) begin
    if (rst_ni) begin
      item_t it;
      n_chk++;
      if (err_o !== (d2v ? d2e : 1'b0)) begin
        n_fail++;
        $display("FAIL %s err_o got %b exp %b", d2v ? d2t : "R7", err_o, d2v ? d2e : 1'b0);
      end
      d2v = d1v; d2e = d1e; d2t = d1t;
      d1v = 1'b0; d1e = 1'b0; d1t = "";
      if (valid_o) begin
        n_chk++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R7 valid_o got 1 exp 0");
        end else begin
          it = q.pop_front();
          if (result_o !== it.res) begin
            n_fail++;
            $display("FAIL %s result_o got %h exp %h", it.tag, result_o, it.res);
          end
          d1v = 1'b1; d1e = it.err; d1t = it.tag;
        end
      end
    end
  end

  task automatic run();
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0 || err_o !== 1'b0 || result_o !== 16'd0) begin
      n_fail++;
      $display("FAIL R8 reset outputs got %b/%h/%b exp 0/0000/0", valid_o, result_o, err_o);
    end
    rst_ni = 1'b1;
    idle(2);
    // R1
    issue(3'd0, 2'd3, 16'h1234, 16'hBEEF, 1'b1, 16'h5555, 16'h0, "R1");
    issue(3'd1, 2'd0, 16'h1234, 16'hBEEF, 1'b0, 16'h0, 16'h0, "R1");
    issue(3'd2, 2'd1, 16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 16'h0, "R1");
    issue(3'd3, 2'd2, 16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 16'h0, "R1");
    issue(3'd7, 2'd3, 16'hABCD, 16'h1357, 1'b1, 16'h2468, 16'h0, "R1");
    idle(3);
    // R2 carry / borrow wrap
    issue(3'd4, 2'd0, 16'hFFFF, 16'h0001, 1'b0, 16'h0, 16'h0, "R2");
    issue(3'd4, 2'd1, 16'hFFFF, 16'h0000, 1'b1, 16'h0, 16'h0, "R2");
    issue(3'd4, 2'd2, 16'h0000, 16'h0001, 1'b0, 16'h0, 16'h0, "R2");
    issue(3'd4, 2'd3, 16'h0005, 16'h0003, 1'b0, 16'h0, 16'h0, "R2");
    issue(3'd4, 2'd3, 16'h0005, 16'h0003, 1'b1, 16'h0, 16'h0, "R2");
    // R3 shifts / rotates
    issue(3'd5, 2'd0, 16'hC3A5, 16'h0000, 1'b0, 16'h0, 16'h0, "R3");
    issue(3'd5, 2'd0, 16'hC3A5, 16'h000F, 1'b0, 16'h0, 16'h0, "R3");
    issue(3'd5, 2'd1, 16'hC3A5, 16'h000F, 1'b0, 16'h0, 16'h0, "R3");
    issue(3'd5, 2'd2, 16'h8001, 16'h0001, 1'b0, 16'h0, 16'h0, "R3");
    issue(3'd5, 2'd3, 16'h1234, 16'h0004, 1'b0, 16'h0, 16'h0, "R3");
    issue(3'd5, 2'd1, 16'hFFFF, 16'h0007, 1'b0, 16'h0, 16'h0, "R3");
    // R4 multiply / accumulate
    issue(3'd6, 2'd0, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0, 16'h0, "R4");
    issue(3'd6, 2'd1, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0, 16'h0, "R4");
    issue(3'd6, 2'd2, 16'h1234, 16'h5678, 1'b0, 16'hFFFF, 16'h0, "R4");
    issue(3'd6, 2'd3, 16'h8000, 16'h7FFF, 1'b0, 16'hF000, 16'h0, "R4");
    idle(2);
    // R5 single-bit injection on various classes
    issue(3'd4, 2'd0, 16'h1111, 16'h2222, 1'b0, 16'h0, 16'h0001, "R5");
    issue(3'd6, 2'd2, 16'hFFFF, 16'h0003, 1'b0, 16'h0100, 16'h8000, "R5");
    issue(3'd5, 2'd2, 16'h00F0, 16'h0003, 1'b0, 16'h0, 16'h0400, "R5");
    // R9 aliasing pair: 00 -> 11 is +3*2^i
    issue(3'd0, 2'd0, 16'h0000, 16'h0, 1'b0, 16'h0, 16'h0003, "R9");
    issue(3'd0, 2'd0, 16'h0000, 16'h0, 1'b0, 16'h0, 16'h0060, "R9");
    issue(3'd0, 2'd0, 16'h0001, 16'h0, 1'b0, 16'h0, 16'h0003, "R9");
    issue(3'd3, 2'd0, 16'h0000, 16'h0, 1'b0, 16'h0, 16'h4000, "R9");
    idle(4);
    // random mix: R5 R6 R7
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] fl;
      fl = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
      issue(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 16'($urandom),
            16'($urandom), 1'($urandom), 16'($urandom), fl, (fl != 0) ? "R5" : "R6");
      if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R7 pending results got %0d exp 0", q.size());
    end
  endtask

  initial begin
    fork
      run();
      begin
        repeat (200000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got timeout exp completion");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule